// File: doc/BRIEF.md
# Prescaled Frequency Counter with Residue Recovery

This block counts the rising edges of an external pulse stream over a gate window that is a fixed number of reference clock cycles long. The input is synchronised, edge-detected and fed into a divide-by-256 prescaler. Software and other logic cannot read the prescaler's internal state. Each prescaler wrap adds 256 to a BCD accumulator. Because the result is built in BCD as the count runs, no binary-to-decimal step is needed at the end.

When the window closes, the external path is cut off. The controller then recovers what was left in the prescaler. It drives single injected pulses into the prescaler, one every two reference cycles, and counts them as k until the prescaler wraps. The missing residue is then 256 − k. It is added to the accumulator one unit per cycle, which makes the result exact. The wrap caused by an injected pulse is never counted.

An optional high-speed mode places a fixed divide-by-64 stage ahead of the prescaler. In that mode every increment is weighted by 64.

Top module: `prescaled_freq_meter`

## Requirements
- R1: In normal mode (hs_mode_i low at start), result_o equals the exact number of rising edges of sig_i that fall inside the gate window.
- R2: When the windowed count is a multiple of 256, including zero, the residue is reported as 0. In that case 256 injected pulses are needed, and the wrap they cause is not added.
- R3: result_o is unsigned packed BCD. Digit i sits in bits [4i+3:4i], with the least significant digit in bits [3:0], and every digit is in the range 0 to 9.
- R4: Edges of sig_i before the start, after the window closes, or during residue recovery do not change the result.
- R5: The residue is recovered by injected pulses that are at least two reference cycles apart. Results with a residue of 1 and of 255 are exact.
- R6: In high-speed mode, result_o equals 64 × floor(N/64) for N edges in the window. hs_mode_i is sampled only when a start is accepted.
- R7: done_o is high for exactly one cycle when result_o becomes valid. result_o then holds its value until the next accepted start.
- R8: A start_i pulse while a measurement is in progress is ignored. The window is not restarted and the count is not cleared.
- R9: After reset, result_o is 0 and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; sets the gate window length |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sig_i | input | 1 | Asynchronous pulse stream to be measured |
| start_i | input | 1 | Begins a measurement when the block is idle |
| hs_mode_i | input | 1 | Selects the divide-by-64 front stage, sampled at start |
| result_o | output | 4*DIGITS | Packed BCD edge count |
| done_o | output | 1 | One-cycle strobe when result_o is valid |

## Verification
The bench aims at residue corner cases, using edge counts of 0, 1, 255, 256, 257 and 513, plus a mid-range count.

- A controller that added the wrap caused by the final injected pulse would be 256 too high on exact multiples.
- An off-by-one in k would shift every result by one.
- Pulses placed before the start and inside the recovery phase would inflate the result if the input were not blocked.

In high-speed mode, a count just below 64 must read 0, and a mid-window toggle of hs_mode_i must have no effect. A restart in mid-window would show up as lost counts. A result that drifted after done, or a strobe wider than one cycle, would be flagged by the monitor.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GATE,
    ST_INJ,
    ST_GAP,
    ST_ADD
  } fcm_state_e;

  // elaboration-time binary to packed BCD, 16 digits max
  function automatic logic [63:0] to_bcd(input longint unsigned v);
    logic [63:0] r;
    longint unsigned t;
    r = '0;
    t = v;
    for (int i = 0; i < 16; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction
endpackage

// File: rtl/fcm_sync_edge.sv
module fcm_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [1:0] sync_q;
  logic       prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], async_i};
      prev_q <= sync_q[1];
    end
  end

  assign rise_o = sync_q[1] & ~prev_q;
endmodule

// File: rtl/fcm_divider.sv
module fcm_divider #(
  parameter int DIV = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic wrap_o
);
  localparam int CW = $clog2(DIV);

  logic [CW-1:0] cnt_q;

  assign wrap_o = inc_i && (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + CW'(1);
  end

  assert_wrap_returns_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && !clr_i) |=> (cnt_q == '0));
endmodule

// File: rtl/fcm_bcd_add.sv
module fcm_bcd_add #(
  parameter int DIGITS = 8
) (
  input  logic [4*DIGITS-1:0] a_i,
  input  logic [4*DIGITS-1:0] b_i,
  output logic [4*DIGITS-1:0] sum_o
);
  always_comb begin
    logic       cy;
    logic [4:0] raw;
    cy    = 1'b0;
    sum_o = '0;
    for (int i = 0; i < DIGITS; i++) begin
      raw = {1'b0, a_i[4*i +: 4]} + {1'b0, b_i[4*i +: 4]} + {4'b0, cy};
      if (raw > 5'd9) begin
        sum_o[4*i +: 4] = raw[3:0] + 4'd6;
        cy = 1'b1;
      end else begin
        sum_o[4*i +: 4] = raw[3:0];
        cy = 1'b0;
      end
    end
  end
endmodule

// File: rtl/prescaled_freq_meter.sv
module prescaled_freq_meter #(
  parameter int GATE_CYCLES = 50_000_000,
  parameter int PRE_DIV     = 256,
  parameter int HS_DIV      = 64,
  parameter int DIGITS      = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sig_i,
  input  logic                start_i,
  input  logic                hs_mode_i,
  output logic [4*DIGITS-1:0] result_o,
  output logic                done_o
);
  import fcm_pkg::*;

  localparam int TW = $clog2(GATE_CYCLES);
  localparam int KW = $clog2(PRE_DIV) + 1;
  localparam int RW = 4 * DIGITS;
  localparam logic [63:0] WRAP_LO = to_bcd(longint'(PRE_DIV));
  localparam logic [63:0] WRAP_HI = to_bcd(longint'(PRE_DIV) * longint'(HS_DIV));
  localparam logic [63:0] UNIT_LO = to_bcd(64'd1);
  localparam logic [63:0] UNIT_HI = to_bcd(longint'(HS_DIV));

  fcm_state_e    state_q;
  logic [TW-1:0] timer_q;
  logic [KW-1:0] k_q, rem_q;
  logic [RW-1:0] acc_q, addend, sum;
  logic          hs_q, done_q;
  logic          rise, hs_wrap, pre_inc, pre_wrap, gate_on, clr, add_en, gate_wrap;

  fcm_sync_edge u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(sig_i),
    .rise_o (rise)
  );

  assign gate_on = (state_q == ST_GATE);
  assign clr     = (state_q == ST_IDLE) && start_i;

  fcm_divider #(.DIV(HS_DIV)) u_front (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .inc_i (rise && gate_on && hs_q),
    .wrap_o(hs_wrap)
  );

  // external path only while gated; injected pulses otherwise
  assign pre_inc = gate_on ? (hs_q ? hs_wrap : rise) : (state_q == ST_INJ);

  fcm_divider #(.DIV(PRE_DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .inc_i (pre_inc),
    .wrap_o(pre_wrap)
  );

  assign gate_wrap = gate_on && pre_wrap;
  assign add_en    = gate_wrap || ((state_q == ST_ADD) && (rem_q != '0));
  assign addend    = gate_wrap ? (hs_q ? WRAP_HI[RW-1:0] : WRAP_LO[RW-1:0])
                               : (hs_q ? UNIT_HI[RW-1:0] : UNIT_LO[RW-1:0]);

  fcm_bcd_add #(.DIGITS(DIGITS)) u_add (
    .a_i  (acc_q),
    .b_i  (addend),
    .sum_o(sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      timer_q <= '0;
      k_q     <= '0;
      rem_q   <= '0;
      acc_q   <= '0;
      hs_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (clr)         acc_q <= '0;
      else if (add_en) acc_q <= sum;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          timer_q <= '0;
          k_q     <= '0;
          hs_q    <= hs_mode_i;
          state_q <= ST_GATE;
        end
        ST_GATE: begin
          if (timer_q == TW'(GATE_CYCLES - 1)) state_q <= ST_INJ;
          else timer_q <= timer_q + TW'(1);
        end
        ST_INJ: begin
          if (pre_wrap) begin
            rem_q   <= KW'(PRE_DIV) - k_q - KW'(1);
            state_q <= ST_ADD;
          end else begin
            k_q     <= k_q + KW'(1);
            state_q <= ST_GAP;
          end
        end
        ST_GAP: state_q <= ST_INJ;
        ST_ADD: begin
          if (rem_q == '0) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            rem_q <= rem_q - KW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign result_o = acc_q;
  assign done_o   = done_q;

  for (genvar i = 0; i < DIGITS; i++) begin : g_bcd_chk
    assert_bcd_digit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_q[4*i +: 4] <= 4'd9);
  end

  assert_inject_spacing_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_INJ) |=> (state_q != ST_INJ));

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_result_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && ($past(state_q) == ST_IDLE)) |-> $stable(result_o));

  assert_busy_no_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_GATE) && (timer_q != '0)) |=>
      ((state_q != ST_GATE) || (timer_q != '0)));
endmodule

// File: tb/prescaled_freq_meter_test.sv
module prescaled_freq_meter_test;
  localparam int CLK_PERIOD = 10;
  localparam int GATE       = 5000;
  localparam int DIGITS     = 8;
  localparam int RW         = 4 * DIGITS;

  logic clk = 1'b0, rst_n = 1'b0, sig = 1'b0, start = 1'b0, hs = 1'b0;
  logic [RW-1:0] result;
  logic done, done_prev;
  int n_cmp = 0, n_bad = 0;
  logic [RW-1:0] exp_q[$];
  string tag_q[$];
  logic [RW-1:0] last_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  prescaled_freq_meter #(.GATE_CYCLES(GATE), .DIGITS(DIGITS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sig_i(sig), .start_i(start),
    .hs_mode_i(hs), .result_o(result), .done_o(done)
  );

  function automatic logic [RW-1:0] bcd(input int v);
    logic [RW-1:0] r = '0;
    for (int i = 0; i < DIGITS; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sig = 1'b1;
      @(negedge clk);
      @(negedge clk) sig = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic kick(input bit h);
    @(negedge clk) begin start = 1'b1; hs = h; end
    @(negedge clk) begin start = 1'b0; hs = ~h; end  // R6: later level ignored
  endtask

  task automatic wait_done;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic measure(input int n, input bit h, input int expv, input string tag);
    exp_q.push_back(bcd(expv));
    tag_q.push_back(tag);
    kick(h);
    repeat (5) @(negedge clk);
    pulses(n);
    wait_done();
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R7: unexpected done, actual %h expected none", result);
        end else begin
          string t;
          logic [RW-1:0] e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          last_exp = e;
          check(t, result, e);
          n_cmp++;
          for (int i = 0; i < DIGITS; i++)
            if (result[4*i +: 4] > 4'd9) begin
              n_bad++;
              $display("FAIL R3: digit %0d actual %h expected <=9", i, result[4*i +: 4]);
              break;
            end
        end
      end
      if (done && done_prev) begin
        n_cmp++; n_bad++;
        $display("FAIL R7: done width actual >1 expected 1");
      end
      done_prev <= done;
    end else begin
      done_prev <= 1'b0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R9 result after reset", result, '0);
    check("R9 done after reset", {{(RW-1){1'b0}}, done}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    measure(0,    1'b0, 0,    "R2 zero count");
    measure(1,    1'b0, 1,    "R5 residue 1");
    measure(255,  1'b0, 255,  "R5 residue 255");
    measure(256,  1'b0, 256,  "R2 exact 256");
    measure(257,  1'b0, 257,  "R1 count 257");
    measure(513,  1'b0, 513,  "R1 count 513");
    measure(1000, 1'b0, 1000, "R1 count 1000");
    measure(933,  1'b1, 896,  "R6 high-speed 933");
    measure(63,   1'b1, 0,    "R6 high-speed 63");

    // R4: edges before start and during recovery are ignored
    pulses(20);
    exp_q.push_back(bcd(100));
    tag_q.push_back("R4 outside-window edges");
    kick(1'b0);
    repeat (5) @(negedge clk);
    pulses(100);
    repeat (GATE - 400 + 20) @(negedge clk);
    pulses(30);
    wait_done();

    // R7: result holds in idle while input toggles
    pulses(40);
    repeat (10) @(negedge clk);
    check("R7 result hold", result, last_exp);

    // R8: second start mid-window is ignored
    exp_q.push_back(bcd(300));
    tag_q.push_back("R8 start while busy");
    kick(1'b0);
    repeat (5) @(negedge clk);
    pulses(150);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    pulses(150);
    wait_done();

    repeat (5) @(negedge clk);
    check("R1 scoreboard drained", RW'(exp_q.size()), '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule